// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of hardware debug triggers and decides, for every memory or fetch access a core presents, whether one of them fires. Each access is described by its kind (instruction fetch, store or load), its address, its data value and the privilege level it runs at. Every trigger filters the access by kind and by privilege. It then compares either the address or the data against its own compare register, using one of six compare modes. The result is a hit flag, the index of the trigger that fired and that trigger's action code. The same cycle that presents the access receives the result.

Triggers can be linked into chains. A trigger with its link bit set can only match when the trigger just below it matched. A trigger whose upper neighbour is linked never fires alone; its match only arms that neighbour. While the core reports a nonzero debug cause, nothing fires. Software-side programming arrives through a small write port. A select register picks the trigger, and control and compare writes go to the trigger it names.

Top module: `trig_match_unit`

## Requirements
- R1: After reset the select register is 0, every trigger has action code 0 (off) and a compare value of 0, so no access produces a hit.
- R2: A configuration write with cfg_addr 0 loads the select register from the low index bits of cfg_wdata. cfg_addr 1 loads the control record of the selected trigger, and cfg_addr 2 loads its compare register. Other triggers keep their contents. The control layout is: action [2:0], link [3], mode [6:4], use-data [7], user enable [8], supervisor enable [9], hypervisor enable [10], machine enable [11], fetch enable [12], store enable [13], load enable [14].
- R3: A trigger takes no part in matching when its action code is 0, or when the enable bit for the access kind is clear. Access kind codes are fetch 0, store 1 and load 2; code 3 never matches.
- R4: A trigger takes no part in matching when the enable bit for acc_priv is clear. The privilege codes are user 0, supervisor 1, hypervisor 2 and machine 3.
- R5: With use-data set the trigger compares acc_data; with use-data clear it compares acc_addr.
- R6: Mode 0 matches when the value equals the compare register. Mode 2 matches when the value is at least the compare register, and mode 3 when it is below it; both comparisons are unsigned.
- R7: Mode 1 counts the run of 1 bits at the bottom of the compare register, ignores that many low bits of both operands, and requires the remaining bits to be equal.
- R8: Mode 4 takes the upper half of the compare register as a mask and matches when (low half of value AND mask) equals (compare register AND mask). Mode 5 performs the same check on the upper half of the value.
- R9: A linked trigger matches only when the trigger directly below it matched; trigger 0 with its link bit set never matches. A matching trigger whose upper neighbour is linked does not fire.
- R10: When several triggers fire, the lowest index is reported.
- R11: While dbg_cause is nonzero, hit stays low.
- R12: hit is high only while acc_valid is high. The outputs follow the access inputs combinationally within the same cycle, and hit_idx and hit_action are 0 whenever hit is low.
- R13: Mode codes 6 and 7 never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration target: 0 select, 1 control, 2 compare |
| cfg_wdata | input | XLEN | Configuration write data |
| acc_valid | input | 1 | Access descriptor valid |
| acc_op | input | 2 | Access kind: 0 fetch, 1 store, 2 load |
| acc_addr | input | XLEN | Access address |
| acc_data | input | XLEN | Access data value |
| acc_priv | input | 2 | Privilege level: 0 U, 1 S, 2 H, 3 M |
| dbg_cause | input | 3 | Debug cause; nonzero means the core is in debug mode |
| hit | output | 1 | A trigger fired |
| hit_idx | output | IDXW | Index of the firing trigger |
| hit_action | output | 3 | Action code of the firing trigger |

## Verification
The hit, index and action outputs are due in the same cycle as the access that produces them, because no register lies between the access inputs and the outputs. The bench therefore drives each access on a falling edge and samples it three nanoseconds later, before the next rising edge. A configuration write takes effect at the rising edge that follows it. Every configuration write is therefore issued in a cycle of its own, with no expectation queued, and the next access is driven only after that edge.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
   localparam int CTRL_W = 15;

   // Control record, MSB first; bit positions define the software layout.
   typedef struct packed {
      logic       load_en;
      logic       store_en;
      logic       exec_en;
      logic       pm;
      logic       ph;
      logic       ps;
      logic       pu;
      logic       use_data;
      logic [2:0] mode;
      logic       link;
      logic [2:0] act;
   } trig_ctrl_t;

   localparam logic [2:0] ACT_OFF    = 3'd0;

   localparam logic [2:0] MODE_EQ    = 3'd0;
   localparam logic [2:0] MODE_NAPOT = 3'd1;
   localparam logic [2:0] MODE_GE    = 3'd2;
   localparam logic [2:0] MODE_LT    = 3'd3;
   localparam logic [2:0] MODE_MLOW  = 3'd4;
   localparam logic [2:0] MODE_MHIGH = 3'd5;

   localparam logic [1:0] OP_EXEC  = 2'd0;
   localparam logic [1:0] OP_STORE = 2'd1;
   localparam logic [1:0] OP_LOAD  = 2'd2;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_H = 2'd2;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam logic [1:0] CFG_SEL  = 2'd0;
   localparam logic [1:0] CFG_CTRL = 2'd1;
   localparam logic [1:0] CFG_CMP  = 2'd2;
endpackage

// File: rtl/trig_cfg_bank.sv
`timescale 1ns/1ps
module trig_cfg_bank
   import trig_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int NTRIG = 4,
   localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_wr,
   input  logic [1:0]                      cfg_addr,
   input  logic [XLEN-1:0]                 cfg_wdata,
   output logic [IDXW-1:0]                 sel_q,
   output trig_ctrl_t [NTRIG-1:0]          ctrl_q,
   output logic [NTRIG-1:0][XLEN-1:0]      cmp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (cfg_wr && cfg_addr == CFG_SEL)
         sel_q <= cfg_wdata[IDXW-1:0];
   end

   for (genvar g = 0; g < NTRIG; g++) begin : g_slot
      logic hit_sel;
      assign hit_sel = (sel_q == IDXW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_q[g] <= '0;
         else if (cfg_wr && hit_sel && cfg_addr == CFG_CTRL)
            ctrl_q[g] <= trig_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_q[g] <= '0;
         else if (cfg_wr && hit_sel && cfg_addr == CFG_CMP)
            cmp_q[g] <= cfg_wdata;
      end
   end
endmodule

// File: rtl/trig_compare.sv
`timescale 1ns/1ps
module trig_compare
   import trig_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int HALF = XLEN / 2
) (
   input  trig_ctrl_t      ctrl,
   input  logic [XLEN-1:0] cmp,
   input  logic [1:0]      acc_op,
   input  logic [1:0]      acc_priv,
   input  logic [XLEN-1:0] acc_addr,
   input  logic [XLEN-1:0] acc_data,
   output logic            raw_match
);
   logic            op_ok, priv_ok, val_ok;
   logic [XLEN-1:0] val;
   logic [XLEN-1:0] ones_run;
   logic [XLEN-1:0] napot_keep;
   logic [HALF-1:0] hmask;

   always_comb begin
      unique case (acc_op)
         OP_EXEC:  op_ok = ctrl.exec_en;
         OP_STORE: op_ok = ctrl.store_en;
         OP_LOAD:  op_ok = ctrl.load_en;
         default:  op_ok = 1'b0;
      endcase
   end

   always_comb begin
      unique case (acc_priv)
         PRIV_U:  priv_ok = ctrl.pu;
         PRIV_S:  priv_ok = ctrl.ps;
         PRIV_H:  priv_ok = ctrl.ph;
         default: priv_ok = ctrl.pm;
      endcase
   end

   assign val = ctrl.use_data ? acc_data : acc_addr;

   // Run of trailing ones in the compare register, bit by bit.
   assign ones_run[0] = cmp[0];
   for (genvar b = 1; b < XLEN; b++) begin : g_run
      assign ones_run[b] = ones_run[b-1] & cmp[b];
   end
   assign napot_keep = ~ones_run;

   assign hmask = cmp[XLEN-1:HALF];

   always_comb begin
      unique case (ctrl.mode)
         MODE_EQ:    val_ok = (val == cmp);
         MODE_NAPOT: val_ok = ((val & napot_keep) == (cmp & napot_keep));
         MODE_GE:    val_ok = (val >= cmp);
         MODE_LT:    val_ok = (val < cmp);
         MODE_MLOW:  val_ok = ((val[HALF-1:0] & hmask) == (cmp[HALF-1:0] & hmask));
         MODE_MHIGH: val_ok = ((val[XLEN-1:HALF] & hmask) == (cmp[HALF-1:0] & hmask));
         default:    val_ok = 1'b0;
      endcase
   end

   assign raw_match = (ctrl.act != ACT_OFF) && op_ok && priv_ok && val_ok;
endmodule

// File: rtl/trig_chain_resolve.sv
`timescale 1ns/1ps
module trig_chain_resolve #(
   parameter int NTRIG = 4,
   localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic [NTRIG-1:0]      raw,
   input  logic [NTRIG-1:0]      link,
   input  logic [NTRIG-1:0][2:0] acts,
   output logic                  found,
   output logic [IDXW-1:0]       idx,
   output logic [2:0]            act
);
   logic [NTRIG-1:0] armed;
   logic [NTRIG-1:0] fire;

   assign armed[0] = raw[0] & ~link[0];
   for (genvar i = 1; i < NTRIG; i++) begin : g_arm
      assign armed[i] = raw[i] & (~link[i] | armed[i-1]);
   end

   for (genvar i = 0; i < NTRIG; i++) begin : g_fire
      if (i == NTRIG - 1) begin : g_top
         assign fire[i] = armed[i];
      end else begin : g_mid
         assign fire[i] = armed[i] & ~link[i+1];
      end
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      act   = '0;
      for (int i = 0; i < NTRIG; i++) begin
         if (fire[i] && !found) begin
            found = 1'b1;
            idx   = IDXW'(i);
            act   = acts[i];
         end
      end
   end
endmodule

// File: rtl/trig_match_unit.sv
`timescale 1ns/1ps
module trig_match_unit
   import trig_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int NTRIG = 4,
   localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr,
   input  logic [1:0]      cfg_addr,
   input  logic [XLEN-1:0] cfg_wdata,
   input  logic            acc_valid,
   input  logic [1:0]      acc_op,
   input  logic [XLEN-1:0] acc_addr,
   input  logic [XLEN-1:0] acc_data,
   input  logic [1:0]      acc_priv,
   input  logic [2:0]      dbg_cause,
   output logic            hit,
   output logic [IDXW-1:0] hit_idx,
   output logic [2:0]      hit_action
);
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("trig_match_unit: XLEN must be 32 or 64");
   end
   if (NTRIG < 2 || (1 << IDXW) != NTRIG) begin : g_bad_ntrig
      $error("trig_match_unit: NTRIG must be a power of two, at least 2");
   end

   logic [IDXW-1:0]            sel_q;
   trig_ctrl_t [NTRIG-1:0]     ctrl_q;
   logic [NTRIG-1:0][XLEN-1:0] cmp_q;
   logic [NTRIG-1:0]           raw, link;
   logic [NTRIG-1:0][2:0]      acts;
   logic                       found;
   logic [IDXW-1:0]            r_idx;
   logic [2:0]                 r_act;
   logic                       live;

   trig_cfg_bank #(.XLEN(XLEN), .NTRIG(NTRIG)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .sel_q     (sel_q),
      .ctrl_q    (ctrl_q),
      .cmp_q     (cmp_q)
   );

   for (genvar t = 0; t < NTRIG; t++) begin : g_trig
      trig_compare #(.XLEN(XLEN)) u_cmp (
         .ctrl      (ctrl_q[t]),
         .cmp       (cmp_q[t]),
         .acc_op    (acc_op),
         .acc_priv  (acc_priv),
         .acc_addr  (acc_addr),
         .acc_data  (acc_data),
         .raw_match (raw[t])
      );
      assign link[t] = ctrl_q[t].link;
      assign acts[t] = ctrl_q[t].act;
   end

   trig_chain_resolve #(.NTRIG(NTRIG)) u_res (
      .raw   (raw),
      .link  (link),
      .acts  (acts),
      .found (found),
      .idx   (r_idx),
      .act   (r_act)
   );

   assign live       = acc_valid && (dbg_cause == 3'd0) && found;
   assign hit        = live;
   assign hit_idx    = live ? r_idx : '0;
   assign hit_action = live ? r_act : 3'd0;
endmodule

// File: rtl/trig_match_unit_chk.sv
`timescale 1ns/1ps
module trig_match_unit_chk #(
   parameter int XLEN = 32,
   parameter int IDXW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_wr,
   input logic [1:0]      cfg_addr,
   input logic [XLEN-1:0] cfg_wdata,
   input logic            acc_valid,
   input logic [1:0]      acc_op,
   input logic [2:0]      dbg_cause,
   input logic            hit,
   input logic [IDXW-1:0] hit_idx,
   input logic [2:0]      hit_action,
   input logic [IDXW-1:0] sel_q
);
   // R12
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> acc_valid);

   // R12
   idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0 && hit_action == 3'd0));

   // R11
   no_hit_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_cause != 3'd0) |-> !hit);

   // R3
   fired_action_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_action != 3'd0));

   // R3
   no_hit_bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_op == 2'd3) |-> !hit);

   // R2
   select_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 2'd0) |=> (sel_q == $past(cfg_wdata[IDXW-1:0])));

   // R2
   select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == 2'd0) |=> $stable(sel_q));
endmodule

bind trig_match_unit trig_match_unit_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .acc_valid  (acc_valid),
   .acc_op     (acc_op),
   .dbg_cause  (dbg_cause),
   .hit        (hit),
   .hit_idx    (hit_idx),
   .hit_action (hit_action),
   .sel_q      (sel_q)
);

// File: tb/trig_match_unit_test.sv
`timescale 1ns/1ps
module trig_match_unit_test;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr = 1'b0;
   logic [1:0]      cfg_addr = '0;
   logic [XLEN-1:0] cfg_wdata = '0;
   logic            acc_valid = 1'b0;
   logic [1:0]      acc_op = '0;
   logic [XLEN-1:0] acc_addr = '0;
   logic [XLEN-1:0] acc_data = '0;
   logic [1:0]      acc_priv = 2'd3;
   logic [2:0]      dbg_cause = '0;
   logic            hit;
   logic [1:0]      hit_idx;
   logic [2:0]      hit_action;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic       h;
      logic [1:0] i;
      logic [2:0] a;
      string      req;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   trig_match_unit #(.XLEN(XLEN), .NTRIG(4)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_op(acc_op),
      .acc_addr(acc_addr), .acc_data(acc_data), .acc_priv(acc_priv),
      .dbg_cause(dbg_cause), .hit(hit), .hit_idx(hit_idx),
      .hit_action(hit_action)
   );

   // ops = {load, store, fetch}, pv = {M, H, S, U}
   function automatic logic [31:0] mk(input logic [2:0] act, input logic lnk,
                                      input logic [2:0] mode, input logic usedat,
                                      input logic [3:0] pv, input logic [2:0] ops);
      return {17'd0, ops, pv, usedat, mode, lnk, act};
   endfunction

   task automatic cfg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b0;
      cfg_wr    = 1'b1;
      cfg_addr  = a;
      cfg_wdata = d;
      @(posedge clk);
      #1 cfg_wr = 1'b0;
   endtask

   task automatic acc(input logic v, input logic [1:0] op, input logic [31:0] ad,
                      input logic [31:0] dt, input logic [1:0] pv, input logic [2:0] cause,
                      input logic eh, input logic [1:0] ei, input logic [2:0] ea,
                      input string req);
      exp_t e;
      @(negedge clk);
      acc_valid = v; acc_op = op; acc_addr = ad; acc_data = dt;
      acc_priv = pv; dbg_cause = cause;
      e.h = eh; e.i = ei; e.a = ea; e.req = req;
      q.push_back(e);
   endtask

   // Monitor: results are due in the same cycle as the access.
   always begin
      exp_t e;
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (hit !== e.h || hit_idx !== e.i || hit_action !== e.a) begin
            fails++;
            $display("FAIL %s: got hit=%0b idx=%0d act=%0d, expected hit=%0b idx=%0d act=%0d",
                     e.req, hit, hit_idx, hit_action, e.h, e.i, e.a);
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      acc(0, 0, 32'h1000, 0, 3, 0, 0, 0, 0, "R12 idle after reset");
      acc(1, 0, 32'h1000, 0, 3, 0, 0, 0, 0, "R1 all triggers off");

      cfg(0, 0);
      cfg(1, mk(3'd2, 0, 3'd0, 0, 4'hF, 3'b001));
      cfg(2, 32'h1000);
      acc(1, 0, 32'h1000, 0, 3, 0, 1, 0, 2, "R6 equal hit");
      acc(1, 0, 32'h1004, 0, 3, 0, 0, 0, 0, "R6 equal miss");
      acc(1, 2, 32'h1000, 0, 3, 0, 0, 0, 0, "R3 load not enabled");
      acc(1, 3, 32'h1000, 0, 3, 0, 0, 0, 0, "R3 op code 3");
      acc(0, 0, 32'h1000, 0, 3, 0, 0, 0, 0, "R12 valid low");
      acc(1, 0, 32'h1000, 0, 3, 3, 0, 0, 0, "R11 debug cause set");

      cfg(1, mk(3'd2, 0, 3'd0, 0, 4'b1000, 3'b001));
      acc(1, 0, 32'h1000, 0, 0, 0, 0, 0, 0, "R4 user blocked");
      acc(1, 0, 32'h1000, 0, 1, 0, 0, 0, 0, "R4 supervisor blocked");
      acc(1, 0, 32'h1000, 0, 3, 0, 1, 0, 2, "R4 machine allowed");

      cfg(0, 1);
      cfg(1, mk(3'd1, 0, 3'd2, 1, 4'hF, 3'b100));
      cfg(2, 32'h500);
      acc(1, 2, 32'h1000, 32'h500, 3, 0, 1, 1, 1, "R6 ge on data equal");
      acc(1, 2, 32'h1000, 32'h4FF, 3, 0, 0, 0, 0, "R6 ge on data below");
      acc(1, 2, 32'h600, 32'h400, 3, 0, 0, 0, 0, "R5 data not address");

      cfg(0, 2);
      cfg(1, mk(3'd3, 0, 3'd3, 0, 4'hF, 3'b010));
      cfg(2, 32'h100);
      acc(1, 1, 32'hFF, 0, 3, 0, 1, 2, 3, "R6 lt below");
      acc(1, 1, 32'h100, 0, 3, 0, 0, 0, 0, "R6 lt at bound");

      cfg(0, 3);
      cfg(1, mk(3'd4, 0, 3'd1, 0, 4'hF, 3'b001));
      cfg(2, 32'h2000_0FFF);
      acc(1, 0, 32'h2000_0ABC, 0, 3, 0, 1, 3, 4, "R7 napot inside");
      acc(1, 0, 32'h2000_0000, 0, 3, 0, 1, 3, 4, "R7 napot base");
      acc(1, 0, 32'h2000_1000, 0, 3, 0, 0, 0, 0, "R7 napot outside");

      cfg(0, 2);
      cfg(1, mk(3'd3, 0, 3'd4, 0, 4'hF, 3'b010));
      cfg(2, 32'h00FF_0034);
      acc(1, 1, 32'hABCD_1234, 0, 3, 0, 1, 2, 3, "R8 mask low hit");
      acc(1, 1, 32'hABCD_1235, 0, 3, 0, 0, 0, 0, "R8 mask low miss");
      cfg(1, mk(3'd3, 0, 3'd5, 0, 4'hF, 3'b010));
      cfg(2, 32'hFF00_5600);
      acc(1, 1, 32'h56AB_0000, 0, 3, 0, 1, 2, 3, "R8 mask high hit");
      acc(1, 1, 32'h57AB_0000, 0, 3, 0, 0, 0, 0, "R8 mask high miss");
      cfg(1, mk(3'd3, 0, 3'd6, 0, 4'hF, 3'b010));
      acc(1, 1, 32'h56AB_0000, 0, 3, 0, 0, 0, 0, "R13 mode 6 never matches");

      cfg(0, 1);
      cfg(1, mk(3'd1, 0, 3'd0, 0, 4'hF, 3'b010));
      cfg(2, 32'h3000);
      cfg(0, 2);
      cfg(1, mk(3'd3, 0, 3'd2, 0, 4'hF, 3'b010));
      cfg(2, 32'h0);
      acc(1, 1, 32'h3000, 0, 3, 0, 1, 1, 1, "R10 lowest index wins");
      acc(1, 1, 32'h3004, 0, 3, 0, 1, 2, 3, "R10 only upper matches");

      cfg(1, mk(3'd3, 1, 3'd3, 0, 4'hF, 3'b010));
      cfg(2, 32'h3001);
      acc(1, 1, 32'h3000, 0, 3, 0, 1, 2, 3, "R9 chain both match");
      acc(1, 1, 32'h2000, 0, 3, 0, 0, 0, 0, "R9 lower fails");
      cfg(2, 32'h3000);
      acc(1, 1, 32'h3000, 0, 3, 0, 0, 0, 0, "R9 lower alone does not fire");

      cfg(0, 0);
      cfg(1, mk(3'd2, 1, 3'd0, 0, 4'hF, 3'b001));
      acc(1, 0, 32'h1000, 0, 3, 0, 0, 0, 0, "R9 trigger 0 linked");

      cfg(0, 3);
      cfg(1, mk(3'd0, 0, 3'd1, 0, 4'hF, 3'b001));
      acc(1, 0, 32'h2000_0ABC, 0, 3, 0, 0, 0, 0, "R3 action off skipped");

      cfg(0, 0);
      cfg(1, mk(3'd2, 0, 3'd0, 0, 4'hF, 3'b001));
      acc(1, 0, 32'h1000, 0, 0, 0, 1, 0, 2, "R2 compare kept, control routed");

      wait (q.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      summary();
   end
endmodule